// File: doc/BRIEF.md
# JTAG Auto-Increment Memory Block Access

This block is a JTAG data register paired with a small bus master. It lets a debug host move a long run of memory locations quickly. A preceding single-location access fixes three things: a starting address, an access size (byte, halfword or word) and a direction (read or write). That access is represented here by a configuration load port. After it, every DR scan under the block's instruction moves exactly one data item. No address is shifted. The stored address steps forward by 1, 2 or 4, and the stored direction is repeated.

For reads, the bus read of the next location starts when the instruction is entered, and again at every Update-DR that completes an access. The returned data is placed in the 34-bit shift register at Capture-DR. For writes, the 32 data bits shifted in are written at Update-DR. In both directions, the first two bits shifted out are a busy flag and a sticky error flag. The host uses them to detect a bus that has not yet answered, or an access that failed. The IR capture value also reports the busy flag, the error flag and a protection input.

Top module: `jtag_block_access`

## Requirements
- R1: At Capture-IR the instruction register loads {prot, error, busy, 0, 1}, bit 0 being the least significant and first shifted out. IR bits shift LSB first. The block becomes selected at Update-IR only if the 5-bit value shifted in is 10010 (0x12).
- R2: While selected, the DR is 34 bits long. A bit presented on tdi in shift cycle n appears on tdo in shift cycle n+34.
- R3: At Capture-DR the DR loads the busy flag in bit 0, the error flag in bit 1 and the 32-bit data field in bits 33:2.
- R4: On entry to the instruction in read direction, one bus read is issued at the configured address plus the step of the configured size. In write direction, entry issues no bus request.
- R5: After each completed read scan, Update-DR advances the address by 1, 2 or 4 (size codes 0, 1, 2) and issues the read of the new address. A scan cut short before 34 bits behaves the same.
- R6: In write direction, Update-DR writes DR bits 33:2 (the 32 bits shifted in) with the stored size at the current address plus step, then advances.
- R7: If a bus transaction is still outstanding at Capture-DR, busy reads 1. The following Update-DR issues nothing and leaves the address unchanged, so the next scan retries the same location.
- R8: A bus response with the error input high sets the error flag. The flag stays set across scans until the next Update-IR.
- R9: Byte reads return the data zero-extended from bits 7:0, and halfword reads return it zero-extended from bits 15:0.
- R10: bus_req stays high with stable address, size, direction and write data until bus_ack, and drops after it. bus_req is low after reset.
- R11: When another instruction is selected, DR scans and updates issue no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_ir | input | 1 | TAP in Capture-IR |
| shift_ir | input | 1 | TAP in Shift-IR |
| update_ir | input | 1 | TAP in Update-IR |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (IR LSB during Shift-IR, else DR LSB) |
| prot | input | 1 | Protection flag reported at Capture-IR |
| cfg_load | input | 1 | Load last single-access parameters |
| cfg_addr | input | ADDR_W | Address of the last single access |
| cfg_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| cfg_write | input | 1 | Direction: 1 write, 0 read |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_addr | output | ADDR_W | Bus address |
| bus_size | output | 2 | Bus access size code |
| bus_we | output | 1 | Bus write enable |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Bus acknowledge, one cycle |
| bus_err | input | 1 | Bus error, valid with acknowledge |

## Verification
The bench goes after the address step for each of the three sizes. A wrong stride would read or write the wrong location, and the data returned from an address-derived memory would not match. It scans while a slow bus is still busy. A design that advanced anyway would skip a location on the retry scan. It injects one bus error and confirms the flag survives the next scan and is cleared only by an instruction load; a design that cleared it per scan would hide failures. It also cuts a read scan short, checks that write entry starts no bus cycle, and scans under another instruction. A design that leaked a bus request in either of those cases would show an extra request.

// File: rtl/jtag_bab_pkg.sv
package jtag_bab_pkg;
  localparam int IR_LEN = 5;
  localparam logic [IR_LEN-1:0] BLOCK_OPCODE = 5'h12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // address stride for a size code; code 3 is treated as a word
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/jtag_ba_ir.sv
module jtag_ba_ir
  import jtag_bab_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  input  logic tdi,
  input  logic prot,
  input  logic err,
  input  logic busy,
  output logic ir_tdo,
  output logic sel,
  output logic enter
);
  logic [IR_LEN-1:0] ir_q, ir_d;
  logic              sel_d;

  always_comb begin
    ir_d = ir_q;
    if (capture_ir)    ir_d = {prot, err, busy, 2'b01};
    else if (shift_ir) ir_d = {tdi, ir_q[IR_LEN-1:1]};
    sel_d = update_ir ? (ir_q == BLOCK_OPCODE) : sel;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      sel  <= 1'b0;
    end else begin
      ir_q <= ir_d;
      sel  <= sel_d;
    end
  end

  assign ir_tdo = ir_q[0];
  assign enter  = update_ir && (ir_q == BLOCK_OPCODE);

  // R1: selection only ever starts at an instruction update
  a_r1_sel_from_update: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(sel) |-> $past(update_ir));
endmodule

// File: rtl/jtag_ba_dr.sv
module jtag_ba_dr #(
  parameter int DR_W = 34
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            en,
  input  logic            capture,
  input  logic            shift,
  input  logic            tdi,
  input  logic [DR_W-1:0] cap_val,
  output logic [DR_W-1:0] sr
);
  logic [DR_W-1:0] sr_d;

  always_comb begin
    sr_d = sr;
    if (en && capture)    sr_d = cap_val;
    else if (en && shift) sr_d = {tdi, sr[DR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_d;
  end
endmodule

// File: rtl/jtag_ba_seq.sv
module jtag_ba_seq
  import jtag_bab_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_write,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_next,
  output logic [1:0]        size,
  output logic              write
);
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        size_d;
  logic              write_d;

  assign addr_next = addr + ADDR_W'(size_step(size));

  always_comb begin
    addr_d  = addr;
    size_d  = size;
    write_d = write;
    if (cfg_load) begin
      addr_d  = cfg_addr + ADDR_W'(size_step(cfg_size));
      size_d  = cfg_size;
      write_d = cfg_write;
    end else if (advance) begin
      addr_d  = addr_next;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      size  <= 2'd0;
      write <= 1'b0;
    end else begin
      addr  <= addr_d;
      size  <= size_d;
      write <= write_d;
    end
  end

  // R7: the address moves only on a load or an accepted access
  a_r7_addr_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (!cfg_load && !advance) |=> $stable(addr));
endmodule

// File: rtl/jtag_ba_bus.sv
module jtag_ba_bus #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              ld_we,
  input  logic [DATA_W-1:0] ld_wdata,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        size,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic              ack,
  input  logic              err_in,
  output logic [DATA_W-1:0] rbuf,
  output logic              err_hit
);
  logic              req_d, we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        size_d;
  logic [DATA_W-1:0] wdata_d, rbuf_d, lane_mask;

  always_comb begin
    case (size)
      2'd0:    lane_mask = DATA_W'(8'hFF);
      2'd1:    lane_mask = DATA_W'(16'hFFFF);
      default: lane_mask = '1;
    endcase
  end

  always_comb begin
    req_d = req; addr_d = addr; size_d = size; we_d = we;
    wdata_d = wdata; rbuf_d = rbuf;
    if (req && ack) begin
      req_d = 1'b0;
      if (!we) rbuf_d = rdata & lane_mask;
    end
    if (launch) begin
      req_d = 1'b1; addr_d = ld_addr; size_d = ld_size;
      we_d = ld_we; wdata_d = ld_wdata;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0; addr <= '0; size <= 2'd0; we <= 1'b0;
      wdata <= '0; rbuf <= '0;
    end else begin
      req <= req_d; addr <= addr_d; size <= size_d; we <= we_d;
      wdata <= wdata_d; rbuf <= rbuf_d;
    end
  end

  assign err_hit = req && ack && err_in;

  // R10: request attributes hold until acknowledged
  a_r10_req_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(size) && $stable(we) && $stable(wdata)));
  // R10: a new access is only started on an idle bus
  a_r10_launch_idle: assert property (@(posedge tck) disable iff (!rst_n)
    launch |-> !req);
endmodule

// File: rtl/jtag_block_access.sv
module jtag_block_access
  import jtag_bab_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              capture_ir,
  input  logic              shift_ir,
  input  logic              update_ir,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              prot,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_write,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err
);
  localparam int DR_W = DATA_W + 2;

  logic              sel, enter, ir_tdo, err_hit;
  logic              err_q, err_d, scan_ok, scan_ok_d;
  logic              dr_act, launch;
  logic [DR_W-1:0]   sr;
  logic [DATA_W-1:0] rbuf;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, launch_addr;
  logic [1:0]        cur_size;
  logic              cur_write;

  jtag_ba_ir u_ir (
    .tck(tck), .rst_n(rst_n), .capture_ir(capture_ir), .shift_ir(shift_ir),
    .update_ir(update_ir), .tdi(tdi), .prot(prot), .err(err_q), .busy(bus_req),
    .ir_tdo(ir_tdo), .sel(sel), .enter(enter)
  );

  jtag_ba_dr #(.DR_W(DR_W)) u_dr (
    .tck(tck), .rst_n(rst_n), .en(sel), .capture(capture_dr), .shift(shift_dr),
    .tdi(tdi), .cap_val({rbuf, err_q, bus_req}), .sr(sr)
  );

  jtag_ba_seq #(.ADDR_W(ADDR_W)) u_seq (
    .tck(tck), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_write(cfg_write), .advance(dr_act),
    .addr(cur_addr), .addr_next(nxt_addr), .size(cur_size), .write(cur_write)
  );

  jtag_ba_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .tck(tck), .rst_n(rst_n), .launch(launch), .ld_addr(launch_addr),
    .ld_size(cur_size), .ld_we(cur_write), .ld_wdata(sr[DR_W-1:2]),
    .req(bus_req), .addr(bus_addr), .size(bus_size), .we(bus_we),
    .wdata(bus_wdata), .rdata(bus_rdata), .ack(bus_ack), .err_in(bus_err),
    .rbuf(rbuf), .err_hit(err_hit)
  );

  // an update acts only if its capture found the bus idle
  assign dr_act      = update_dr && sel && scan_ok;
  assign launch      = (enter && !cur_write && !bus_req) || dr_act;
  assign launch_addr = (dr_act && !cur_write) ? nxt_addr : cur_addr;
  assign tdo         = shift_ir ? ir_tdo : sr[0];

  always_comb begin
    err_d = err_q;
    if (err_hit)        err_d = 1'b1;
    else if (update_ir) err_d = 1'b0;
    scan_ok_d = scan_ok;
    if (capture_dr && sel) scan_ok_d = !bus_req;
    else if (update_dr)    scan_ok_d = 1'b0;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      scan_ok <= 1'b0;
    end else begin
      err_q   <= err_d;
      scan_ok <= scan_ok_d;
    end
  end

  // R7: an update after a busy capture starts no bus cycle
  a_r7_busy_drop: assert property (@(posedge tck) disable iff (!rst_n)
    (update_dr && !scan_ok && !update_ir) |=> !$rose(bus_req));
  // R8: error flag survives everything but an instruction load
  a_r8_err_sticky: assert property (@(posedge tck) disable iff (!rst_n)
    (err_q && !update_ir) |=> err_q);
  // R11: no bus activity while another instruction is active
  a_r11_unselected_quiet: assert property (@(posedge tck) disable iff (!rst_n)
    (!sel && !update_ir) |=> !$rose(bus_req));
endmodule

// File: tb/jtag_block_access_tb_top.sv
`timescale 1ns/1ps
module jtag_block_access_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr, tdi, prot;
  logic cfg_load, cfg_write;
  logic [31:0] cfg_addr;
  logic [1:0]  cfg_size;
  logic tdo, bus_req, bus_we, bus_ack, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  always #2 clk = ~clk;

  jtag_block_access dut_i (
    .tck(clk), .rst_n(rst_n), .capture_ir(capture_ir), .shift_ir(shift_ir),
    .update_ir(update_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .prot(prot),
    .cfg_load(cfg_load), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
    .cfg_write(cfg_write), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_at(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[15:0]};
  endfunction

  function automatic logic [31:0] stride(input logic [1:0] s);
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] keep(input logic [1:0] s, input logic [31:0] d);
    if (s == 2'd0) return d & 32'hFF;
    if (s == 2'd1) return d & 32'hFFFF;
    return d;
  endfunction

  // ---------------- bus responder and request log ----------------
  int lat = 2, cnt = 0, req_cnt = 0;
  bit err_arm = 0;
  logic [31:0] log_addr[$], log_wdata[$];
  logic        log_we[$];
  logic [1:0]  log_size[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack <= 0; bus_err <= 0; bus_rdata <= 0; cnt = 0;
    end else if (bus_ack) begin
      bus_ack <= 0; bus_err <= 0;
    end else if (bus_req) begin
      if (cnt >= lat) begin
        bus_ack <= 1; bus_err <= err_arm; err_arm = 0;
        bus_rdata <= mem_at(bus_addr);
        log_addr.push_back(bus_addr); log_we.push_back(bus_we);
        log_wdata.push_back(bus_wdata); log_size.push_back(bus_size);
        req_cnt++; cnt = 0;
      end else cnt++;
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [4:0]  m_ir;
  logic [33:0] m_sr;
  logic [31:0] m_addr, m_rbuf, m_baddr, m_bwd;
  logic [1:0]  m_size;
  logic        m_wr, m_sel, m_pend, m_bwe, m_err, m_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ir = 0; m_sr = 0; m_addr = 0; m_rbuf = 0; m_baddr = 0; m_bwd = 0;
      m_size = 0; m_wr = 0; m_sel = 0; m_pend = 0; m_bwe = 0; m_err = 0; m_ok = 0;
    end else begin
      automatic logic [4:0]  o_ir = m_ir;
      automatic logic [33:0] o_sr = m_sr;
      automatic logic o_sel = m_sel, o_pend = m_pend, o_err = m_err, o_ok = m_ok;
      automatic logic [31:0] o_addr = m_addr;
      automatic bit entering = update_ir && (o_ir == 5'h12);
      automatic bit act = update_dr && o_sel && o_ok;
      automatic bit go = (entering && !m_wr && !o_pend) || act;
      automatic logic [31:0] where = (act && !m_wr) ? o_addr + stride(m_size) : o_addr;
      if (capture_ir) m_ir = {prot, o_err, o_pend, 2'b01};
      else if (shift_ir) m_ir = {tdi, o_ir[4:1]};
      if (update_ir) m_sel = (o_ir == 5'h12);
      if (o_sel && capture_dr) m_sr = {m_rbuf, o_err, o_pend};
      else if (o_sel && shift_dr) m_sr = {tdi, o_sr[33:1]};
      if (o_sel && capture_dr) m_ok = !o_pend;
      else if (update_dr) m_ok = 0;
      if (o_pend && bus_ack && bus_err) m_err = 1;
      else if (update_ir) m_err = 0;
      if (o_pend && bus_ack) begin
        m_pend = 0;
        if (!m_bwe) m_rbuf = keep(m_size, bus_rdata);
      end
      if (go) begin
        m_pend = 1; m_baddr = where; m_bwe = m_wr; m_bwd = o_sr[33:2];
      end
      if (cfg_load) begin
        m_addr = cfg_addr + stride(cfg_size); m_size = cfg_size; m_wr = cfg_write;
      end else if (act) m_addr = o_addr + stride(m_size);
    end
  end

  // per-clock comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(bus_req === m_pend, "R10 bus_req vs model", bus_req, m_pend);
      if (m_pend) begin
        chk(bus_addr === m_baddr, "R5 bus_addr vs model", bus_addr, m_baddr);
        chk(bus_we === m_bwe, "R6 bus_we vs model", bus_we, m_bwe);
        if (m_bwe) chk(bus_wdata === m_bwd, "R6 bus_wdata vs model", bus_wdata, m_bwd);
      end
      chk(tdo === (shift_ir ? m_ir[0] : m_sr[0]), "R2 tdo vs model", tdo,
          shift_ir ? m_ir[0] : m_sr[0]);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cfg(input logic [31:0] a, input logic [1:0] s, input logic w);
    @(negedge clk); cfg_load = 1; cfg_addr = a; cfg_size = s; cfg_write = w;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic ir_scan(input logic [4:0] v, output logic [4:0] got);
    got = 0;
    @(negedge clk); capture_ir = 1;
    @(negedge clk); capture_ir = 0;
    for (int i = 0; i < 5; i++) begin
      shift_ir = 1; tdi = v[i]; #1 got[i] = tdo; @(negedge clk);
    end
    shift_ir = 0; update_ir = 1;
    @(negedge clk); update_ir = 0;
  endtask

  task automatic dr_scan(input logic [79:0] vin, input int n, output logic [79:0] got);
    got = 0;
    @(negedge clk); capture_dr = 1;
    @(negedge clk); capture_dr = 0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1; tdi = vin[i]; #1 got[i] = tdo; @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk); update_dr = 0;
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [4:0]  g5;
    logic [79:0] g;
    int c0;
    rst_n = 0; capture_ir = 0; shift_ir = 0; update_ir = 0; capture_dr = 0;
    shift_dr = 0; update_dr = 0; tdi = 0; prot = 1; cfg_load = 0;
    cfg_addr = 0; cfg_size = 0; cfg_write = 0;
    idle(3); rst_n = 1; idle(1);
    #1;
    chk(bus_req === 1'b0, "R10 reset bus_req", bus_req, 0);
    chk(tdo === 1'b0, "R3 reset tdo", tdo, 0);

    // word reads
    load_cfg(32'h100, 2'd2, 0);
    ir_scan(5'h12, g5);
    chk(g5 === 5'b10001, "R1 IR capture pattern", g5, 5'b10001);
    idle(8);
    chk(req_cnt == 1 && log_addr[$] == 32'h104, "R4 entry read address", log_addr[$], 32'h104);
    dr_scan(0, 34, g);
    chk(g[1:0] === 2'b00, "R3 busy/error bits", g[1:0], 0);
    chk(g[33:2] === mem_at(32'h104), "R3 read data field", g[33:2], mem_at(32'h104));
    idle(8);
    chk(log_addr[$] == 32'h108 && !log_we[$], "R5 word step read", log_addr[$], 32'h108);
    dr_scan(0, 34, g);
    chk(g[33:2] === mem_at(32'h108), "R5 second word data", g[33:2], mem_at(32'h108));
    idle(8);
    dr_scan(0, 6, g);
    idle(8);
    chk(log_addr[$] == 32'h110, "R5 short scan still advances", log_addr[$], 32'h110);
    dr_scan(0, 34, g);
    chk(g[33:2] === mem_at(32'h110), "R5 data after short scan", g[33:2], mem_at(32'h110));
    idle(8);
    dr_scan({46'd0, 34'h1_5A5A_C3C3}, 68, g);
    chk(g[67:34] === 34'h1_5A5A_C3C3, "R2 34-bit length", g[67:34], 34'h1_5A5A_C3C3);
    idle(8);

    // byte and halfword reads
    load_cfg(32'h200, 2'd0, 0);
    ir_scan(5'h12, g5);
    idle(8);
    chk(log_addr[$] == 32'h201 && log_size[$] == 2'd0, "R4 byte entry address", log_addr[$], 32'h201);
    dr_scan(0, 34, g);
    chk(g[33:2] === (mem_at(32'h201) & 32'hFF), "R9 byte zero-extended", g[33:2], mem_at(32'h201) & 32'hFF);
    idle(8);
    chk(log_addr[$] == 32'h202, "R5 byte step", log_addr[$], 32'h202);
    load_cfg(32'h300, 2'd1, 0);
    ir_scan(5'h12, g5);
    idle(8);
    dr_scan(0, 34, g);
    chk(g[33:2] === (mem_at(32'h302) & 32'hFFFF), "R9 half zero-extended", g[33:2], mem_at(32'h302) & 32'hFFFF);
    idle(8);
    chk(log_addr[$] == 32'h304, "R5 half step", log_addr[$], 32'h304);

    // busy retry
    lat = 40;
    idle(50);
    load_cfg(32'h600, 2'd2, 0);
    ir_scan(5'h12, g5);
    c0 = req_cnt;
    dr_scan(0, 34, g);
    chk(g[0] === 1'b1, "R7 busy seen at capture", g[0], 1);
    idle(50);
    chk(req_cnt == c0 + 1 && bus_req === 1'b0, "R7 busy update issued nothing", req_cnt, c0 + 1);
    lat = 2;
    dr_scan(0, 34, g);
    chk(g[0] === 1'b0 && g[33:2] === mem_at(32'h604), "R7 retry same location", g[33:2], mem_at(32'h604));
    idle(8);

    // sticky error
    load_cfg(32'h700, 2'd2, 0);
    err_arm = 1;
    ir_scan(5'h12, g5);
    idle(8);
    dr_scan(0, 34, g);
    chk(g[1] === 1'b1, "R8 error reported", g[1], 1);
    idle(8);
    dr_scan(0, 34, g);
    chk(g[1] === 1'b1, "R8 error still set", g[1], 1);
    idle(8);
    ir_scan(5'h12, g5);
    chk(g5[3] === 1'b1, "R1 IR error bit", g5[3], 1);
    idle(8);
    dr_scan(0, 34, g);
    chk(g[1] === 1'b0, "R8 cleared by instruction load", g[1], 0);
    idle(8);

    // writes
    load_cfg(32'h400, 2'd2, 1);
    ir_scan(5'h12, g5);
    c0 = req_cnt;
    idle(6);
    chk(req_cnt == c0 && bus_req === 1'b0, "R4 write entry no request", req_cnt, c0);
    dr_scan({48'd0, 32'hCAFEF00D}, 32, g);
    chk(g[0] === 1'b0, "R3 write scan busy clear", g[0], 0);
    idle(8);
    chk(log_addr[$] == 32'h404 && log_we[$] && log_wdata[$] == 32'hCAFEF00D, "R6 first write", log_wdata[$], 32'hCAFEF00D);
    dr_scan({48'd0, 32'h12345678}, 32, g);
    idle(8);
    chk(log_addr[$] == 32'h408 && log_wdata[$] == 32'h12345678, "R6 second write address", log_addr[$], 32'h408);
    load_cfg(32'h500, 2'd1, 1);
    dr_scan({48'd0, 32'h0000BEEF}, 32, g);
    idle(8);
    chk(log_addr[$] == 32'h502 && log_size[$] == 2'd1, "R6 halfword write", log_addr[$], 32'h502);

    // unselected
    ir_scan(5'h01, g5);
    c0 = req_cnt;
    dr_scan(0, 34, g);
    idle(8);
    chk(req_cnt == c0 && bus_req === 1'b0, "R11 other instruction quiet", req_cnt, c0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule